// File: doc/BRIEF.md
# Transaction Nesting and Fallback Unit

This unit keeps track of one logical processor's hardware transactional regions. A begin strobe carries a signed relative displacement (16 or 32 bits wide) and the address of the instruction that follows the begin. At the outermost begin, the unit forms the fallback target from these two values. It checks that target for legality and holds it for the whole nest. End strobes unwind the nest. When the nest is fully unwound, the unit gives a commit pulse. An abort sends the processor back to the held target and clears the entire nest at once.

All control inputs are plain single-cycle strobes. The unit can act on one event in every cycle, so there is no back-pressure and no ready signal. Every output is registered. Each result appears in the cycle after the strobe that causes it.

Top module: `txn_nest_unit`

## Requirements
- R1: A begin (with no abort in the same cycle) raises `tx_depth` by one when the depth is below `MAX_NEST`. The depth never goes above `MAX_NEST` (default 7).
- R2: A begin at depth 0 latches `fallback_ip` = next-instruction address + sign-extended displacement. `begin_wide`=1 selects all 32 bits of `begin_imm`, and `begin_wide`=0 selects bits 15:0. Begins at nonzero depth leave `fallback_ip` unchanged.
- R3: With `mode64`=1, the full 64-bit sum is used. The target is illegal when bits 63..47 are not all equal.
- R4: With `mode64`=0, the sum is formed on bits 31:0 and wraps modulo 2^32. The upper 32 bits of the target are zero. The target is illegal when it is strictly greater than `cs_limit`.
- R5: An outermost begin with an illegal target pulses `gp_fault` for one cycle. The depth stays 0, `tx_active` stays 0, and `fallback_ip` is not changed.
- R6: An end at depth above 1 lowers the depth by one. An end at depth 1 sets the depth to 0, clears `tx_active` and pulses `commit_pulse` for one cycle.
- R7: An end at depth 0 pulses `gp_fault` and changes nothing else.
- R8: An abort at nonzero depth pulses `redirect_vld` with `redirect_ip` equal to the outermost target. In that same output cycle, the depth is 0 and `tx_active` is 0.
- R9: A begin that arrives when the depth is already `MAX_NEST` is handled exactly like an abort (R8).
- R10: An abort strobe makes any begin or end in the same cycle be ignored. An abort at depth 0 has no effect. A begin takes precedence over an end that arrives with it in the same cycle. At most one of `gp_fault`, `commit_pulse` and `redirect_vld` is high in any cycle.
- R11: After reset, the depth is 0, all pulses are low, `tx_active` is 0, and both addresses are 0. `tx_active` is 1 exactly when the depth is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| begin_vld | input | 1 | Begin strobe |
| begin_wide | input | 1 | 1: 32-bit displacement, 0: 16-bit |
| begin_imm | input | 32 | Displacement (low 16 bits used when narrow) |
| begin_next_ip | input | 64 | Address of the instruction after the begin |
| end_vld | input | 1 | End strobe |
| abort_vld | input | 1 | Abort strobe |
| mode64 | input | 1 | 1: 64-bit addressing, 0: 32-bit with limit check |
| cs_limit | input | 32 | Code segment limit (inclusive) |
| tx_active | output | 1 | Transactional execution in progress |
| tx_depth | output | 3 | Current nesting depth |
| fallback_ip | output | 64 | Target latched at the outermost begin |
| gp_fault | output | 1 | One-cycle fault pulse |
| commit_pulse | output | 1 | One-cycle pulse when the nest fully unwinds |
| redirect_vld | output | 1 | One-cycle redirect pulse on abort |
| redirect_ip | output | 64 | Redirect address, valid with redirect_vld |

## Verification
The events most likely to collide are an abort and a begin in the same cycle. There are two forms. An explicit abort can be driven together with a begin, and a begin that arrives at full depth is turned into an abort inside the unit. The bench drives an abort together with a begin at depth 0 and at nonzero depth, and also a begin together with an end. It then checks that only the higher-priority event changes depth, target and pulses. It fills the nest to its limit and issues one more begin, and checks for a redirect to the outermost target rather than a deeper nest. A randomised phase then mixes all strobes in every cycle against the bench's model.

// File: rtl/txn_nest_pkg.sv
package txn_nest_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE   = 3'd0,
    ACT_ENTER  = 3'd1,
    ACT_NEST   = 3'd2,
    ACT_FAULT  = 3'd3,
    ACT_UNNEST = 3'd4,
    ACT_COMMIT = 3'd5,
    ACT_ABORT  = 3'd6
  } txn_act_e;

endpackage

// File: rtl/txn_target_calc.sv
module txn_target_calc #(
  parameter int ADDR_W    = 64,
  parameter int IMM_W     = 32,
  parameter int SHORT_W   = 16,
  parameter int NARROW_W  = 32,
  parameter int CANON_MSB = 47
) (
  input  logic [IMM_W-1:0]    imm,
  input  logic                wide,
  input  logic [ADDR_W-1:0]   next_ip,
  input  logic                mode64,
  input  logic [NARROW_W-1:0] cs_limit,
  output logic [ADDR_W-1:0]   target,
  output logic                illegal
);

  localparam int CANON_W = ADDR_W - CANON_MSB;

  logic [ADDR_W-1:0]   disp;
  logic [ADDR_W-1:0]   sum_full;
  logic [NARROW_W-1:0] sum_narrow;
  logic [CANON_W-1:0]  canon_field;
  logic                canonical;

  // Sign-extend the displacement from whichever width was selected
  always_comb begin
    if (wide)
      disp = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    else
      disp = {{(ADDR_W-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
  end

  assign sum_full    = next_ip + disp;
  assign sum_narrow  = next_ip[NARROW_W-1:0] + disp[NARROW_W-1:0];
  assign canon_field = sum_full[ADDR_W-1:CANON_MSB];
  assign canonical   = (&canon_field) | ~(|canon_field);

  always_comb begin
    if (mode64) begin
      target  = sum_full;
      illegal = ~canonical;
    end else begin
      target  = {{(ADDR_W-NARROW_W){1'b0}}, sum_narrow};
      illegal = (sum_narrow > cs_limit);
    end
  end

endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
  import txn_nest_pkg::*;
#(
  parameter int MAX_NEST = 7,
  parameter int DEPTH_W  = 3
) (
  input  logic               begin_vld,
  input  logic               end_vld,
  input  logic               abort_vld,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               illegal,
  output txn_act_e           act
);

  localparam logic [DEPTH_W-1:0] MAX_D = DEPTH_W'(MAX_NEST);
  localparam logic [DEPTH_W-1:0] ONE_D = DEPTH_W'(1);

  logic at_zero;
  logic at_max;

  assign at_zero = (depth == '0);
  assign at_max  = (depth == MAX_D);

  // Priority: abort, then begin, then end
  always_comb begin
    act = ACT_IDLE;
    if (abort_vld) begin
      if (!at_zero) act = ACT_ABORT;
    end else if (begin_vld) begin
      if (at_max)       act = ACT_ABORT;
      else if (at_zero) act = illegal ? ACT_FAULT : ACT_ENTER;
      else              act = ACT_NEST;
    end else if (end_vld) begin
      if (at_zero)            act = ACT_FAULT;
      else if (depth == ONE_D) act = ACT_COMMIT;
      else                    act = ACT_UNNEST;
    end
  end

endmodule

// File: rtl/txn_depth_ctr.sv
module txn_depth_ctr
  import txn_nest_pkg::*;
#(
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  txn_act_e           act,
  output logic [DEPTH_W-1:0] depth,
  output logic               active
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth  <= '0;
      active <= 1'b0;
    end else begin
      unique case (act)
        ACT_ENTER: begin
          depth  <= DEPTH_W'(1);
          active <= 1'b1;
        end
        ACT_NEST:   depth <= depth + DEPTH_W'(1);
        ACT_UNNEST: depth <= depth - DEPTH_W'(1);
        ACT_COMMIT, ACT_ABORT: begin
          depth  <= '0;
          active <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/txn_nest_unit.sv
module txn_nest_unit
  import txn_nest_pkg::*;
#(
  parameter int MAX_NEST  = 7,
  parameter int ADDR_W    = 64,
  parameter int IMM_W     = 32,
  parameter int SHORT_W   = 16,
  parameter int NARROW_W  = 32,
  parameter int CANON_MSB = 47,
  localparam int DEPTH_W  = $clog2(MAX_NEST + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                begin_vld,
  input  logic                begin_wide,
  input  logic [IMM_W-1:0]    begin_imm,
  input  logic [ADDR_W-1:0]   begin_next_ip,
  input  logic                end_vld,
  input  logic                abort_vld,
  input  logic                mode64,
  input  logic [NARROW_W-1:0] cs_limit,
  output logic                tx_active,
  output logic [DEPTH_W-1:0]  tx_depth,
  output logic [ADDR_W-1:0]   fallback_ip,
  output logic                gp_fault,
  output logic                commit_pulse,
  output logic                redirect_vld,
  output logic [ADDR_W-1:0]   redirect_ip
);

  logic [ADDR_W-1:0] cand_target;
  logic              cand_illegal;
  txn_act_e          act;

  txn_target_calc #(
    .ADDR_W   (ADDR_W),
    .IMM_W    (IMM_W),
    .SHORT_W  (SHORT_W),
    .NARROW_W (NARROW_W),
    .CANON_MSB(CANON_MSB)
  ) u_calc (
    .imm     (begin_imm),
    .wide    (begin_wide),
    .next_ip (begin_next_ip),
    .mode64  (mode64),
    .cs_limit(cs_limit),
    .target  (cand_target),
    .illegal (cand_illegal)
  );

  txn_nest_ctrl #(
    .MAX_NEST(MAX_NEST),
    .DEPTH_W (DEPTH_W)
  ) u_ctrl (
    .begin_vld(begin_vld),
    .end_vld  (end_vld),
    .abort_vld(abort_vld),
    .depth    (tx_depth),
    .illegal  (cand_illegal),
    .act      (act)
  );

  txn_depth_ctr #(
    .DEPTH_W(DEPTH_W)
  ) u_depth (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .depth (tx_depth),
    .active(tx_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fallback_ip  <= '0;
      redirect_ip  <= '0;
      gp_fault     <= 1'b0;
      commit_pulse <= 1'b0;
      redirect_vld <= 1'b0;
    end else begin
      gp_fault     <= (act == ACT_FAULT);
      commit_pulse <= (act == ACT_COMMIT);
      redirect_vld <= (act == ACT_ABORT);
      if (act == ACT_ENTER) fallback_ip <= cand_target;
      if (act == ACT_ABORT) redirect_ip <= fallback_ip;
    end
  end

endmodule

// File: rtl/txn_nest_chk.sv
module txn_nest_chk #(
  parameter int MAX_NEST = 7,
  parameter int ADDR_W   = 64,
  parameter int DEPTH_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               begin_vld,
  input logic               end_vld,
  input logic               abort_vld,
  input logic               tx_active,
  input logic [DEPTH_W-1:0] tx_depth,
  input logic [ADDR_W-1:0]  fallback_ip,
  input logic               gp_fault,
  input logic               commit_pulse,
  input logic               redirect_vld,
  input logic [ADDR_W-1:0]  redirect_ip
);

  localparam logic [DEPTH_W-1:0] MAX_D = DEPTH_W'(MAX_NEST);

  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_depth <= MAX_D);

  // R1
  nest_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_vld && !abort_vld && tx_depth != '0 && tx_depth < MAX_D)
      |=> (tx_depth == $past(tx_depth) + DEPTH_W'(1)));

  // R2
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_depth != '0) |=> $stable(fallback_ip));

  // R6
  commit_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (tx_depth == '0 && !tx_active));

  // R7
  empty_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_vld && !begin_vld && !abort_vld && tx_depth == '0) |=> gp_fault);

  // R8
  redirect_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> (tx_depth == '0 && !tx_active && redirect_ip == fallback_ip));

  // R9
  full_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_vld && !abort_vld && tx_depth == MAX_D) |=> redirect_vld);

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gp_fault, commit_pulse, redirect_vld}));

  // R11
  active_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active == (tx_depth != '0));

endmodule

bind txn_nest_unit txn_nest_chk #(
  .MAX_NEST(MAX_NEST),
  .ADDR_W  (ADDR_W),
  .DEPTH_W (DEPTH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .begin_vld   (begin_vld),
  .end_vld     (end_vld),
  .abort_vld   (abort_vld),
  .tx_active   (tx_active),
  .tx_depth    (tx_depth),
  .fallback_ip (fallback_ip),
  .gp_fault    (gp_fault),
  .commit_pulse(commit_pulse),
  .redirect_vld(redirect_vld),
  .redirect_ip (redirect_ip)
);

// File: tb/txn_nest_unit_tb.sv
`timescale 1ns/1ps
module txn_nest_unit_tb;

  localparam int MAXN = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        begin_vld = 1'b0;
  logic        begin_wide = 1'b0;
  logic [31:0] begin_imm = '0;
  logic [63:0] begin_next_ip = '0;
  logic        end_vld = 1'b0;
  logic        abort_vld = 1'b0;
  logic        mode64 = 1'b0;
  logic [31:0] cs_limit = '0;
  logic        tx_active;
  logic [2:0]  tx_depth;
  logic [63:0] fallback_ip;
  logic        gp_fault;
  logic        commit_pulse;
  logic        redirect_vld;
  logic [63:0] redirect_ip;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  int          m_depth = 0;
  logic [63:0] m_fb = '0;
  logic [63:0] m_rip = '0;
  bit          m_gp = 0, m_commit = 0, m_redir = 0;

  always #4 clk = ~clk;

  txn_nest_unit u_dut (
    .clk(clk), .rst_n(rst_n), .begin_vld(begin_vld), .begin_wide(begin_wide),
    .begin_imm(begin_imm), .begin_next_ip(begin_next_ip), .end_vld(end_vld),
    .abort_vld(abort_vld), .mode64(mode64), .cs_limit(cs_limit),
    .tx_active(tx_active), .tx_depth(tx_depth), .fallback_ip(fallback_ip),
    .gp_fault(gp_fault), .commit_pulse(commit_pulse), .redirect_vld(redirect_vld),
    .redirect_ip(redirect_ip)
  );

  task automatic chk(input string tag, input string nm, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "depth", 64'(tx_depth), 64'(m_depth));
    chk(tag, "active", 64'(tx_active), 64'(m_depth != 0));
    chk(tag, "fallback", fallback_ip, m_fb);
    chk(tag, "gp_fault", 64'(gp_fault), 64'(m_gp));
    chk(tag, "commit", 64'(commit_pulse), 64'(m_commit));
    chk(tag, "redirect_vld", 64'(redirect_vld), 64'(m_redir));
    chk(tag, "redirect_ip", redirect_ip, m_rip);
  endtask

  // One cycle: drive, predict, wait the edge, compare at the falling edge
  task automatic step(input bit b, input bit w, input logic [31:0] imm, input logic [63:0] nip,
                      input bit e, input bit a, input bit m64, input logic [31:0] lim,
                      input string tag);
    longint      d;
    logic [63:0] t;
    logic [31:0] t32;
    bit          bad;
    begin_vld = b; begin_wide = w; begin_imm = imm; begin_next_ip = nip;
    end_vld = e; abort_vld = a; mode64 = m64; cs_limit = lim;
    d = w ? longint'($signed(imm)) : longint'($signed(imm[15:0]));
    if (m64) begin
      t   = nip + 64'(d);
      bad = !((t >> 47) == 64'd0 || (t >> 47) == 64'h1FFFF);
    end else begin
      t32 = nip[31:0] + d[31:0];
      t   = {32'd0, t32};
      bad = (t32 > lim);
    end
    m_gp = 0; m_commit = 0; m_redir = 0;
    if (a) begin
      if (m_depth > 0) begin m_redir = 1; m_rip = m_fb; m_depth = 0; end
    end else if (b) begin
      if (m_depth == MAXN) begin m_redir = 1; m_rip = m_fb; m_depth = 0; end
      else if (m_depth == 0) begin
        if (bad) m_gp = 1;
        else begin m_depth = 1; m_fb = t; end
      end else m_depth++;
    end else if (e) begin
      if (m_depth == 0) m_gp = 1;
      else begin m_depth--; if (m_depth == 0) m_commit = 1; end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 32'd0, 64'd0, 0, 0, 1, 32'd0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    compare_all("R11_reset");

    // R2 R3: narrow negative displacement in 64-bit mode
    step(1, 0, 32'h0000_FFF0, 64'h0000_7FFF_0000_1000, 0, 0, 1, 32'd0, "R2_outer_narrow");
    chk("R2_value", "fallback", fallback_ip, 64'h0000_7FFF_0000_0FF0);
    // R1 R2: inner begins keep the target
    step(1, 1, 32'h1234_5678, 64'h0000_0000_0000_4000, 0, 0, 1, 32'd0, "R1_R2_inner");
    step(1, 0, 32'h0000_0010, 64'h0000_0000_0000_8000, 0, 0, 0, 32'd0, "R1_R2_inner2");
    // R6 unwind one level
    step(0, 0, 32'd0, 64'd0, 1, 0, 1, 32'd0, "R6_unnest");
    // R8 abort redirects to outer target
    step(0, 0, 32'd0, 64'd0, 0, 1, 1, 32'd0, "R8_abort");
    chk("R8_value", "redirect_ip", redirect_ip, 64'h0000_7FFF_0000_0FF0);
    idle("R8_after");
    // R3 R5: non-canonical positive and negative
    step(1, 1, 32'h7FFF_FFFF, 64'h0000_7FFF_9000_0000, 0, 0, 1, 32'd0, "R3_R5_noncanon_hi");
    step(1, 0, 32'h0000_FFE0, 64'hFFFF_8000_0000_0010, 0, 0, 1, 32'd0, "R3_R5_noncanon_lo");
    // R3: canonical upper half accepted
    step(1, 0, 32'h0000_0004, 64'hFFFF_8000_0000_0010, 0, 0, 1, 32'd0, "R3_canon_hi");
    step(0, 0, 32'd0, 64'd0, 1, 0, 1, 32'd0, "R6_commit");
    // R4: wrap modulo 2^32, upper bits dropped
    step(1, 1, 32'h0000_0020, 64'hDEAD_0000_FFFF_FFF0, 0, 0, 0, 32'h1000, "R4_wrap");
    chk("R4_value", "fallback", fallback_ip, 64'h0000_0000_0000_0010);
    step(0, 0, 32'd0, 64'd0, 1, 0, 0, 32'd0, "R6_commit2");
    // R4 R5: beyond limit faults, equal to limit accepted
    step(1, 0, 32'h0000_0900, 64'h0000_0000_0000_0800, 0, 0, 0, 32'h1000, "R4_R5_over");
    step(1, 0, 32'h0000_0800, 64'h0000_0000_0000_0800, 0, 0, 0, 32'h1000, "R4_at_limit");
    step(0, 0, 32'd0, 64'd0, 1, 0, 0, 32'd0, "R6_commit3");
    // R7: end with empty nest
    step(0, 0, 32'd0, 64'd0, 1, 0, 0, 32'd0, "R7_empty_end");
    // R9: fill to maximum then one more begin
    for (int i = 0; i < MAXN; i++)
      step(1, 0, 32'h0000_0100, 64'h0000_0000_0000_2000, 0, 0, 1, 32'd0, "R1_fill");
    step(1, 0, 32'h0000_0100, 64'h0000_0000_0000_2000, 0, 0, 1, 32'd0, "R9_full_begin");
    // R10: abort at depth 0 ignored, abort masks begin
    step(0, 0, 32'd0, 64'd0, 0, 1, 1, 32'd0, "R10_abort_empty");
    step(1, 0, 32'h0000_0040, 64'h0000_0000_0000_3000, 0, 1, 1, 32'd0, "R10_abort_begin_empty");
    // R10: begin beats end
    step(1, 0, 32'h0000_0040, 64'h0000_0000_0000_3000, 1, 0, 1, 32'd0, "R10_begin_end");
    step(1, 0, 32'h0000_0040, 64'h0000_0000_0000_5000, 0, 1, 1, 32'd0, "R10_abort_begin_nest");
    step(1, 0, 32'h0000_0040, 64'h0000_0000_0000_3000, 0, 0, 1, 32'd0, "R2_reenter");
    step(1, 0, 32'h0000_0040, 64'h0000_0000_0000_3000, 1, 0, 1, 32'd0, "R10_begin_end_nest");

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [63:0] nip;
      int sel;
      sel = int'($urandom % 3);
      nip = {$urandom, $urandom};
      if (sel == 0) nip[63:40] = 24'h0;
      else if (sel == 1) nip[63:40] = 24'hFFFFFF;
      step(($urandom % 3) == 0, $urandom % 2, $urandom, nip,
           ($urandom % 3) == 0, ($urandom % 9) == 0, $urandom % 2,
           $urandom % 2 ? 32'hFFFF_0000 : {16'h0, 16'($urandom)}, "R10_random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule